// File: doc/BRIEF.md
# Dual-Clock Threshold Flag Generator

This block produces the two active-low early-warning flags of a FIFO whose write and read sides run on unrelated clocks: one that warns the buffer is nearly full and one that warns it is nearly empty. It takes the occupancy count as seen in each clock domain and two programmable slack values. One slack sets how few entries still count as "nearly empty". The other sets how little free space still counts as "nearly full". Pointer synchronisation and the storage array live elsewhere. Each count arrives already expressed in its own domain.

A timing-mode pin is captured while reset is held. In synchronous mode each flag is owned by one clock and is re-evaluated on every edge of that clock from that domain's count. In asynchronous mode each flag is asserted by one clock and released by the other. Each flag is then held as a pair of toggle bits, one per domain, and the flag is their XOR. A toggle bit moves only when its domain sees that the flag must change state.

Top module: `fifo_thresh_flags`

## Requirements
- R1: The mode is taken from `sync_mode_pin` on the clock edges during which `rst` is high. A 1 selects synchronous timing and a 0 selects asynchronous timing. Changing the pin after reset has no effect on flag behaviour.
- R2: While `rst` is held high over several edges of both clocks, `alm_full_n` reads 1 and `alm_empty_n` reads 0.
- R3: The nearly-empty condition holds when the count is at most `empty_thresh`. The nearly-full condition holds when the count is at least DEPTH minus `full_thresh`. Both thresholds range from 0 to DEPTH-1 and are treated as unsigned.
- R4: In synchronous mode, after each rising `wr_clk` edge, `alm_full_n` is the inverse of the nearly-full condition on the `wr_level` sampled at that edge. `rd_clk` edges do not change it.
- R5: In synchronous mode, after each rising `rd_clk` edge, `alm_empty_n` is the inverse of the nearly-empty condition on the `rd_level` sampled at that edge. `wr_clk` edges do not change it.
- R6: In asynchronous mode, a rising `wr_clk` edge drives `alm_full_n` low when the condition holds on `wr_level`. A rising `rd_clk` edge drives it high when the condition fails on `rd_level`. Otherwise it holds its value.
- R7: In asynchronous mode, a rising `rd_clk` edge drives `alm_empty_n` low when the condition holds on `rd_level`. A rising `wr_clk` edge drives it high when the condition fails on `wr_level`. Otherwise it holds its value.
- R8: When both clock edges fall at the same instant in asynchronous mode, only the edge that would move the flag away from its present state acts. A released flag is asserted and an asserted flag is released, and the two never cancel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst | input | 1 | Active-high reset, synchronous in each domain |
| sync_mode_pin | input | 1 | Timing mode, captured during reset (1 = synchronous) |
| wr_level | input | $clog2(DEPTH+1) | Occupancy as seen in the write domain |
| rd_level | input | $clog2(DEPTH+1) | Occupancy as seen in the read domain |
| empty_thresh | input | $clog2(DEPTH) | Nearly-empty slack |
| full_thresh | input | $clog2(DEPTH) | Nearly-full free-space slack |
| alm_full_n | output | 1 | Nearly-full flag, active low |
| alm_empty_n | output | 1 | Nearly-empty flag, active low |

## Verification
The risky overlap is an assertion and a release of the same flag landing on one instant, with one clock setting and the other clearing. The two clocks have periods of 8 ns and 10 ns and are phased so that their rising edges coincide every 40 ns. Random counts are biased toward the threshold boundaries, so coincident edges often carry conflicting requests. At those instants the outputs are compared with a bench model in which each edge acts only on a flag in the opposite state. Samples taken just after a coincident edge are tagged as R8.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;

  // Nearly-empty: occupancy does not exceed the slack.
  function automatic logic low_water(input int unsigned level, input int unsigned slack);
    return level <= slack;
  endfunction

  // Nearly-full: free room (depth - level) does not exceed the slack.
  function automatic logic high_water(input int unsigned level, input int unsigned slack,
                                      input int unsigned depth);
    return (level + slack) >= depth;
  endfunction

endpackage

// File: rtl/flag_mode_latch.sv
module flag_mode_latch (
  input  logic clk,
  input  logic rst,
  input  logic mode_pin,
  output logic sync_q
);
  // Follows the pin while reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= mode_pin;
  end
endmodule

// File: rtl/flag_core.sv
module flag_core #(
  parameter bit ASSERT_AT_RESET = 1'b0
) (
  input  logic clk_own,    // domain that asserts the flag
  input  logic clk_peer,   // domain that releases it in async mode
  input  logic rst,
  input  logic own_sync,
  input  logic peer_sync,
  input  logic hit_own,
  input  logic hit_peer,
  output logic flag_n,
  output logic set_ev,
  output logic clr_ev
);
  logic sync_q;
  logic tog_own;
  logic tog_peer;
  logic async_on;

  assign async_on = tog_own ^ tog_peer;
  assign set_ev   = !own_sync && hit_own && !async_on;
  assign clr_ev   = !peer_sync && !hit_peer && async_on;

  always_ff @(posedge clk_own) begin
    if (rst) begin
      sync_q  <= ASSERT_AT_RESET;
      tog_own <= ASSERT_AT_RESET;
    end else begin
      sync_q <= hit_own;
      if (set_ev) tog_own <= ~tog_own;
    end
  end

  always_ff @(posedge clk_peer) begin
    if (rst)         tog_peer <= 1'b0;
    else if (clr_ev) tog_peer <= ~tog_peer;
  end

  assign flag_n = own_sync ? !sync_q : !async_on;
endmodule

// File: rtl/fifo_thresh_flags.sv
module fifo_thresh_flags #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned OFF_W = $clog2(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst,
  input  logic             sync_mode_pin,
  input  logic [CNT_W-1:0] wr_level,
  input  logic [CNT_W-1:0] rd_level,
  input  logic [OFF_W-1:0] empty_thresh,
  input  logic [OFF_W-1:0] full_thresh,
  output logic             alm_full_n,
  output logic             alm_empty_n
);
  import fifo_flag_pkg::*;

  logic wr_sync_q, rd_sync_q;
  logic full_hit_w, full_hit_r, empty_hit_w, empty_hit_r;
  logic paf_set_ev, paf_clr_ev, pae_set_ev, pae_clr_ev;

  flag_mode_latch u_mode_wr (.clk(wr_clk), .rst(rst), .mode_pin(sync_mode_pin), .sync_q(wr_sync_q));
  flag_mode_latch u_mode_rd (.clk(rd_clk), .rst(rst), .mode_pin(sync_mode_pin), .sync_q(rd_sync_q));

  assign full_hit_w  = high_water(32'(wr_level), 32'(full_thresh), DEPTH);
  assign full_hit_r  = high_water(32'(rd_level), 32'(full_thresh), DEPTH);
  assign empty_hit_w = low_water(32'(wr_level), 32'(empty_thresh));
  assign empty_hit_r = low_water(32'(rd_level), 32'(empty_thresh));

  flag_core #(.ASSERT_AT_RESET(1'b0)) u_full (
    .clk_own(wr_clk), .clk_peer(rd_clk), .rst(rst),
    .own_sync(wr_sync_q), .peer_sync(rd_sync_q),
    .hit_own(full_hit_w), .hit_peer(full_hit_r),
    .flag_n(alm_full_n), .set_ev(paf_set_ev), .clr_ev(paf_clr_ev)
  );

  flag_core #(.ASSERT_AT_RESET(1'b1)) u_empty (
    .clk_own(rd_clk), .clk_peer(wr_clk), .rst(rst),
    .own_sync(rd_sync_q), .peer_sync(wr_sync_q),
    .hit_own(empty_hit_r), .hit_peer(empty_hit_w),
    .flag_n(alm_empty_n), .set_ev(pae_set_ev), .clr_ev(pae_clr_ev)
  );
endmodule

// File: rtl/fifo_thresh_flags_chk.sv
module fifo_thresh_flags_chk #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned OFF_W = $clog2(DEPTH)
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             rst,
  input logic [CNT_W-1:0] wr_level,
  input logic [CNT_W-1:0] rd_level,
  input logic [OFF_W-1:0] empty_thresh,
  input logic [OFF_W-1:0] full_thresh,
  input logic             alm_full_n,
  input logic             alm_empty_n,
  input logic             wr_sync_q,
  input logic             rd_sync_q,
  input logic             paf_set_ev,
  input logic             paf_clr_ev,
  input logic             pae_set_ev,
  input logic             pae_clr_ev
);
  // Thresholds restated from ports: free room vs. slack, level vs. slack.
  logic near_full_w, near_full_r, near_empty_w, near_empty_r;
  assign near_full_w  = (DEPTH - 32'(wr_level)) <= 32'(full_thresh);
  assign near_full_r  = (DEPTH - 32'(rd_level)) <= 32'(full_thresh);
  assign near_empty_w = !(32'(wr_level) > 32'(empty_thresh));
  assign near_empty_r = !(32'(rd_level) > 32'(empty_thresh));

  AST_SYNC_FULL_TRACK: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_sync_q && !$past(rst)) |-> (alm_full_n == !$past(near_full_w))); // R4

  AST_SYNC_EMPTY_TRACK: assert property (@(posedge rd_clk) disable iff (rst)
    (rd_sync_q && !$past(rst)) |-> (alm_empty_n == !$past(near_empty_r))); // R5

  AST_FULL_SET_ON_HIT: assert property (@(posedge wr_clk) disable iff (rst)
    paf_set_ev |-> (near_full_w && !wr_sync_q)); // R6

  AST_FULL_CLR_ON_MISS: assert property (@(posedge rd_clk) disable iff (rst)
    paf_clr_ev |-> (!near_full_r && !rd_sync_q)); // R6

  AST_EMPTY_SET_ON_HIT: assert property (@(posedge rd_clk) disable iff (rst)
    pae_set_ev |-> (near_empty_r && !rd_sync_q)); // R7

  AST_EMPTY_CLR_ON_MISS: assert property (@(posedge wr_clk) disable iff (rst)
    pae_clr_ev |-> (!near_empty_w && !wr_sync_q)); // R7
endmodule

bind fifo_thresh_flags fifo_thresh_flags_chk #(.DEPTH(DEPTH)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
  .wr_level(wr_level), .rd_level(rd_level),
  .empty_thresh(empty_thresh), .full_thresh(full_thresh),
  .alm_full_n(alm_full_n), .alm_empty_n(alm_empty_n),
  .wr_sync_q(wr_sync_q), .rd_sync_q(rd_sync_q),
  .paf_set_ev(paf_set_ev), .paf_clr_ev(paf_clr_ev),
  .pae_set_ev(pae_set_ev), .pae_clr_ev(pae_clr_ev)
);

// File: tb/tb_fifo_thresh_flags.sv
module tb_fifo_thresh_flags;
  localparam int unsigned DEPTH = 32;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned OFF_W = $clog2(DEPTH);

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst = 1'b1, mode_pin = 1'b1;
  logic [CNT_W-1:0] wr_level = '0, rd_level = '0;
  logic [OFF_W-1:0] n_off = '0, m_off = '0;
  logic alm_full_n, alm_empty_n;

  int vectors = 0, bad = 0;
  bit chk_on = 0, drive_on = 0, done = 0;

  fifo_thresh_flags #(.DEPTH(DEPTH)) dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .sync_mode_pin(mode_pin),
    .wr_level(wr_level), .rd_level(rd_level),
    .empty_thresh(n_off), .full_thresh(m_off),
    .alm_full_n(alm_full_n), .alm_empty_n(alm_empty_n)
  );

  // 125 MHz write clock; 100 MHz read clock, rising edges coincide every 40 ns.
  initial forever #4 wr_clk = ~wr_clk;
  initial begin #4 rd_clk = 1'b1; forever #5 rd_clk = ~rd_clk; end

  function automatic bit is_low(int lvl, int n);  return !(lvl > n);          endfunction
  function automatic bit is_high(int lvl, int m); return (DEPTH - lvl) <= m;  endfunction

  // Bench model: 1 = flag asserted.
  bit mw = 1, mr = 1, e_full = 0, e_empty = 1;
  always @(posedge wr_clk) begin
    if (rst) begin mw <= mode_pin; e_full <= 0; end
    else if (mw) e_full <= is_high(wr_level, m_off);
    else begin
      if (!e_full && is_high(wr_level, m_off)) e_full <= 1;
      if (e_empty && !is_low(wr_level, n_off)) e_empty <= 0;
    end
  end
  always @(posedge rd_clk) begin
    if (rst) begin mr <= mode_pin; e_empty <= 1; end
    else if (mr) e_empty <= is_low(rd_level, n_off);
    else begin
      if (!e_empty && is_low(rd_level, n_off)) e_empty <= 1;
      if (e_full && !is_high(rd_level, m_off)) e_full <= 0;
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    vectors++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic sample_flags();
    string tf, te;
    tf = mw ? "R4 R3" : "R6 R3";
    te = mr ? "R5 R3" : "R7 R3";
    if (($time % 40) == 5) begin tf = {tf, " R8"}; te = {te, " R8"}; end
    if (mode_pin != mw) begin tf = {tf, " R1"}; te = {te, " R1"}; end
    chk(alm_full_n,  !e_full,  tf);
    chk(alm_empty_n, !e_empty, te);
  endtask

  initial forever begin @(posedge wr_clk); #1; if (chk_on) sample_flags(); end
  initial forever begin @(posedge rd_clk); #1; if (chk_on) sample_flags(); end

  function automatic int pick(int n, int m);
    int r;
    r = int'($urandom_range(0, 7));
    case (r)
      0: return n;
      1: return n + 1;
      2: return DEPTH - m;
      3: return DEPTH - m - 1;
      4: return 0;
      5: return DEPTH;
      default: return int'($urandom_range(0, DEPTH));
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] clamp(int v);
    if (v < 0) return '0;
    if (v > int'(DEPTH)) return CNT_W'(DEPTH);
    return CNT_W'(v);
  endfunction

  initial forever begin
    @(negedge wr_clk);
    if (drive_on) wr_level = clamp(pick(int'(n_off), int'(m_off)));
  end
  initial forever begin
    @(negedge rd_clk);
    if (drive_on) rd_level = clamp(pick(int'(n_off), int'(m_off)));
  end

  task automatic do_reset(input bit mode, input int n, input int m);
    drive_on = 0;
    chk_on = 0;
    @(negedge wr_clk); #1;
    rst = 1; mode_pin = mode;
    n_off = OFF_W'(n); m_off = OFF_W'(m);
    wr_level = '0; rd_level = '0;
    repeat (6) @(posedge wr_clk);
    #1;
    chk(alm_full_n,  1'b1, "R2");
    chk(alm_empty_n, 1'b0, "R2");
    @(negedge wr_clk); #1;
    rst = 0;
    mode_pin = ~mode; // R1: must be ignored from here on
    chk_on = 1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));

    // Synchronous mode, directed boundaries of R3/R4/R5 first.
    do_reset(1'b1, 5, 6);
    @(negedge wr_clk); wr_level = CNT_W'(DEPTH - 6);
    @(posedge wr_clk); #1; chk(alm_full_n, 1'b0, "R3 R4 at DEPTH-m");
    @(negedge wr_clk); wr_level = CNT_W'(DEPTH - 7);
    @(posedge wr_clk); #1; chk(alm_full_n, 1'b1, "R3 R4 below DEPTH-m");
    @(negedge rd_clk); rd_level = CNT_W'(6);
    @(posedge rd_clk); #1; chk(alm_empty_n, 1'b1, "R3 R5 at n+1");
    @(negedge rd_clk); rd_level = CNT_W'(5);
    @(posedge rd_clk); #1; chk(alm_empty_n, 1'b0, "R3 R5 at n");
    drive_on = 1;
    repeat (3000) @(posedge wr_clk);

    // Asynchronous mode: directed set by writer, release by reader.
    do_reset(1'b0, 5, 6);
    @(negedge wr_clk); wr_level = CNT_W'(DEPTH);
    @(posedge wr_clk); #1; chk(alm_full_n, 1'b0, "R6 set on wr edge");
    @(negedge rd_clk); rd_level = CNT_W'(DEPTH);
    repeat (3) @(posedge rd_clk); #1; chk(alm_full_n, 1'b0, "R6 held while reader sees full");
    drive_on = 1;
    repeat (3000) @(posedge wr_clk);

    do_reset(1'b0, 0, 0);
    drive_on = 1;
    repeat (3000) @(posedge wr_clk);

    do_reset(1'b0, DEPTH - 1, DEPTH - 1);
    drive_on = 1;
    repeat (3000) @(posedge wr_clk);

    do_reset(1'b0, 9, 4);
    drive_on = 1;
    repeat (3000) @(posedge wr_clk);

    do_reset(1'b1, DEPTH - 1, 0);
    drive_on = 1;
    repeat (2000) @(posedge wr_clk);

    drive_on = 0;
    chk_on = 0;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      vectors++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion at %0t", $time);
      summary();
      $finish;
    end
  end
endmodule